// File: doc/BRIEF.md
# Asymmetric Two-Phase Quench Timer

This block is the digital stand-in for a capacitor-and-Schmitt-trigger quench timer in a duty-cycled oscillator transmitter. It holds an integer level that a controller steers down or up through a single direction input. A high direction input is the sample phase, in which the oscillator may run and the level falls. A low direction input is the quench phase, in which the level rises. A registered phase flag with two hysteresis thresholds tells the controller which phase the timer has reached.

A synchronous clear loads the level with a preload value above the upper threshold, so every cycle starts from the same point. The level falls from the preload to the lower threshold, the flag rises, the controller switches to quench, and the level climbs back to the upper threshold, where the flag drops again. The falling and rising step sizes differ. With the default numbers (preload 120, thresholds 90 and 30, falling step 3, rising step 4) the sample phase takes 30 enabled cycles and the quench phase takes 15, so quench is one third of the whole period. A clock enable sets the update rate, which places the period near 1 µs in the target system.

Top module: `quench_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the phase flag is low (sample) and the level equals the preload value.
- R2: A high clear loads the preload into the level and drives the flag low on the next edge. Clear wins over counting and acts even when the clock enable is low.
- R3: On an enabled edge with the direction input high and no clear, the level falls by the falling step. If the new level is at or below the lower threshold, the flag goes high after that edge.
- R4: On an enabled edge with the direction input low and no clear, the level rises by the rising step. If the new level is at or above the upper threshold, the flag goes low after that edge.
- R5: With the clock enable low and no clear, both the level and the flag hold their values.
- R6: The level saturates at 0 and never wraps below it. After a long fall, the rise time back to the upper threshold is ceil(upper/rising step) enabled cycles, which is 23 by default.
- R7: The level saturates at the preload and never exceeds it. A rise that starts from the preload leaves the level at the preload, so the next fall to the lower threshold still takes 30 enabled cycles.
- R8: From a clear with the defaults, the flag rises after 30 enabled falling cycles. A following rise drops it after 15 enabled cycles. That is a 2:1 sample-to-quench ratio within one step.
- R9: The flag is sticky. It is not cleared while falling and it is not set while rising, whatever the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous preload of the level; also drives the flag low |
| runDir | input | 1 | 1 = sample (level falls), 0 = quench (level rises) |
| clkEn | input | 1 | Update enable for the level and the flag |
| phaseFlag | output | 1 | 0 = sample mode, 1 = quench period |

## Verification
Directed runs start from a clear and measure the sample and quench lengths in enabled cycles. This tells a correct step ratio apart from swapped or equal steps. A long fall followed by a rise, and a rise that starts from the preload, separate saturating arithmetic from wrapping arithmetic, because the phase lengths that follow differ. Runs with the clock enable gated and with clear raised while the enable is low separate the hold and clear priority paths. Random mixes of direction, enable and sparse clears then exercise the sticky hysteresis at every level against a behavioural model.

// File: rtl/quench_timer_pkg.sv
package quench_timer_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic inc;
  } qtStrobe_t;
endpackage

// File: rtl/quench_timer_dp.sv
module quench_timer_dp
  import quench_timer_pkg::*;
#(
  parameter int unsigned LEVEL_W = 8,
  parameter int unsigned PRELOAD = 120,
  parameter int unsigned UPPER   = 90,
  parameter int unsigned LOWER   = 30,
  parameter int unsigned STEP_DN = 3,
  parameter int unsigned STEP_UP = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  qtStrobe_t strb,
  output logic      hitLow,
  output logic      hitHigh
);
  localparam int unsigned WW = LEVEL_W + 1;
  localparam logic [WW-1:0] PRE_W = WW'(PRELOAD);
  localparam logic [WW-1:0] UP_W  = WW'(UPPER);
  localparam logic [WW-1:0] LO_W  = WW'(LOWER);
  localparam logic [WW-1:0] DN_S  = WW'(STEP_DN);
  localparam logic [WW-1:0] UP_S  = WW'(STEP_UP);

  logic [LEVEL_W-1:0] level;
  logic [WW-1:0] levelW, decTry, incRaw, incTry;

  assign levelW = {1'b0, level};

  // saturating candidates for both directions
  always_comb begin
    decTry = (levelW >= DN_S) ? levelW - DN_S : '0;
    incRaw = levelW + UP_S;
    incTry = (incRaw > PRE_W) ? PRE_W : incRaw;
  end

  assign hitLow  = (decTry <= LO_W);
  assign hitHigh = (incTry >= UP_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          level <= PRE_W[LEVEL_W-1:0];
    else if (strb.load) level <= PRE_W[LEVEL_W-1:0];
    else if (strb.dec)  level <= decTry[LEVEL_W-1:0];
    else if (strb.inc)  level <= incTry[LEVEL_W-1:0];
  end
endmodule

// File: rtl/quench_timer_ctrl.sv
module quench_timer_ctrl
  import quench_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clear,
  input  logic      runDir,
  input  logic      clkEn,
  input  logic      hitLow,
  input  logic      hitHigh,
  output qtStrobe_t strb,
  output logic      phaseFlag
);
  always_comb begin
    strb.load = clear;
    strb.dec  = !clear && clkEn && runDir;
    strb.inc  = !clear && clkEn && !runDir;
  end

  // hysteresis: set only on the way down, released only on the way up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    phaseFlag <= 1'b0;
    else if (strb.load)           phaseFlag <= 1'b0;
    else if (strb.dec && hitLow)  phaseFlag <= 1'b1;
    else if (strb.inc && hitHigh) phaseFlag <= 1'b0;
  end
endmodule

// File: rtl/quench_timer.sv
module quench_timer
  import quench_timer_pkg::*;
#(
  parameter int unsigned LEVEL_W = 8,
  parameter int unsigned PRELOAD = 120,
  parameter int unsigned UPPER   = 90,
  parameter int unsigned LOWER   = 30,
  parameter int unsigned STEP_DN = 3,
  parameter int unsigned STEP_UP = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic runDir,
  input  logic clkEn,
  output logic phaseFlag
);
  qtStrobe_t strb;
  logic hitLow, hitHigh;

  quench_timer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .runDir(runDir), .clkEn(clkEn),
    .hitLow(hitLow), .hitHigh(hitHigh), .strb(strb), .phaseFlag(phaseFlag)
  );

  quench_timer_dp #(
    .LEVEL_W(LEVEL_W), .PRELOAD(PRELOAD), .UPPER(UPPER), .LOWER(LOWER),
    .STEP_DN(STEP_DN), .STEP_UP(STEP_UP)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .hitLow(hitLow), .hitHigh(hitHigh)
  );
endmodule

// File: rtl/quench_timer_chk.sv
module quench_timer_chk (
  input logic clk,
  input logic rstN,
  input logic clear,
  input logic runDir,
  input logic clkEn,
  input logic phaseFlag
);
  assert_clear_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !phaseFlag);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !clkEn) |=> $stable(phaseFlag));

  assert_rise_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseFlag) |-> $past(runDir && clkEn && !clear));

  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phaseFlag) |-> $past(clear || (clkEn && !runDir)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phaseFlag && runDir && !clear) |=> phaseFlag);
endmodule

bind quench_timer quench_timer_chk uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .runDir(runDir),
  .clkEn(clkEn), .phaseFlag(phaseFlag)
);

// File: tb/tb_quench_timer.sv
module tb_quench_timer;
  localparam int PRE = 120, UPT = 90, LOT = 30, DN = 3, UP = 4;

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0, runDir = 1'b0, clkEn = 1'b0;
  logic phaseFlag;
  int nChecks = 0, nFails = 0;
  int mLevel = PRE;
  logic mFlag = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quench_timer dut (.clk(clk), .rstN(rstN), .clear(clear), .runDir(runDir),
                    .clkEn(clkEn), .phaseFlag(phaseFlag));

  function automatic int nextLevel(int lv, logic c, logic d, logic e);
    if (c) return PRE;
    if (!e) return lv;
    if (d) return (lv >= DN) ? lv - DN : 0;
    return (lv + UP > PRE) ? PRE : lv + UP;
  endfunction

  function automatic logic nextFlag(int lv, logic f, logic c, logic d, logic e);
    int nl = nextLevel(lv, c, d, e);
    if (c) return 1'b0;
    if (!e) return f;
    if (d && nl <= LOT) return 1'b1;
    if (!d && nl >= UPT) return 1'b0;
    return f;
  endfunction

  task automatic check(string req, logic exp);
    nChecks++;
    if (phaseFlag !== exp) begin
      nFails++;
      $display("FAIL %s: phaseFlag=%b expected=%b at %0t", req, phaseFlag, exp, $time);
    end
  endtask

  // drive one cycle at negedge, compare after the following edge
  task automatic cyc(string req, logic c, logic d, logic e);
    clear = c; runDir = d; clkEn = e;
    mFlag  = nextFlag(mLevel, mFlag, c, d, e);
    mLevel = nextLevel(mLevel, c, d, e);
    @(negedge clk);
    check(req, mFlag);
  endtask

  task automatic measure(string req, logic d, logic target, int expLen);
    int n = 0;
    while (phaseFlag !== target && n < 400) begin
      cyc(req, 1'b0, d, 1'b1);
      n++;
    end
    nChecks++;
    if (n != expLen) begin
      nFails++;
      $display("FAIL %s: length=%0d expected=%0d", req, n, expLen);
    end
  endtask

  initial begin
    int sLen, qLen;
    process::self().srandom(32'h5eed_0017);
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // R8: default period split
    cyc("R2", 1'b1, 1'b1, 1'b1);
    sLen = 0; qLen = 0;
    while (phaseFlag !== 1'b1 && sLen < 400) begin cyc("R3", 1'b0, 1'b1, 1'b1); sLen++; end
    while (phaseFlag !== 1'b0 && qLen < 400) begin cyc("R4", 1'b0, 1'b0, 1'b1); qLen++; end
    nChecks++;
    if (sLen != 30 || qLen != 15 || ((sLen - 2*qLen) > 1) || ((2*qLen - sLen) > 1)) begin
      nFails++;
      $display("FAIL R8: sample=%0d quench=%0d expected=30/15", sLen, qLen);
    end

    // R7: rise from the preload saturates
    cyc("R2", 1'b1, 1'b0, 1'b1);
    repeat (5) cyc("R7", 1'b0, 1'b0, 1'b1);
    measure("R7", 1'b1, 1'b1, 30);

    // R6: long fall to zero then rise
    repeat (50) cyc("R9", 1'b0, 1'b1, 1'b1);
    measure("R6", 1'b0, 1'b0, 23);

    // R5: enable gated holds everything
    cyc("R2", 1'b1, 1'b1, 1'b1);
    repeat (10) cyc("R5", 1'b0, 1'b1, 1'b0);
    measure("R5", 1'b1, 1'b1, 30);
    repeat (6) cyc("R5", 1'b0, 1'b0, 1'b0);
    // R2: clear while enable low
    cyc("R2", 1'b1, 1'b1, 1'b0);
    repeat (4) cyc("R5", 1'b0, 1'b0, 1'b0);
    measure("R2", 1'b1, 1'b1, 30);

    // R9: rising but not yet at upper keeps flag high
    repeat (3) cyc("R9", 1'b0, 1'b0, 1'b1);
    repeat (3) cyc("R9", 1'b0, 1'b1, 1'b1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic rc, rd, re;
      rc = (($urandom % 40) == 0);
      rd = (($urandom % 3) != 0) ? ((i / 40) % 2 == 0) : $urandom % 2;
      re = ($urandom % 4) != 0;
      cyc("R3", rc, rd, re);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule